// File: doc/BRIEF.md
# 48-bit Float Format Converter

This block translates between a compact 48-bit floating-point word and IEEE-754 binary64. The compact word has a sign bit at position 47, a 7-bit exponent at bits 46..40 with an excess of 64, and a 40-bit fraction at bits 39..0 under an implied leading one. A word that is entirely zero stands for 0.0. There are two independent registered paths. The widen path turns a 48-bit word into a double. The narrow path turns a double into a 48-bit word: it rounds the fraction to nearest with ties going up, and it clamps the rebased exponent into the 7-bit range.

A third path gathers a 48-bit word from six bytes that arrive one per cycle in ascending address order. The first byte is the least significant. A host reading memory byte by byte hands the gathered word to the widen path. Every path registers its result and raises a one-cycle done strobe in the cycle after the request is accepted.

Top module: `fmt48_bridge`

## Requirements
- R1: After reset, `unpackDone`, `packDone` and `asmDone` are low, and `dblOut`, `packOut` and `asmWord` are zero.
- R2: One cycle after `unpackReq`, `unpackDone` is high and `dblOut` holds the widened value. For a nonzero word, its bit 63 is input bit 47. Its bits 62..52 are the 7-bit exponent plus 959. Its bits 51..12 are the 40 fraction bits, and its bits 11..0 are zero.
- R3: A 48-bit word of all zeros widens to +0.0 (all 64 bits zero). A word with only bit 47 set is not zero and widens to 0xBBF0000000000000.
- R4: One cycle after `packReq`, `packDone` is high and `packOut` holds the narrowed value. Bit 47 is the double's sign. Bits 46..40 are the double's 11-bit exponent minus 959. Bits 39..0 are the double's fraction bits 51..12 after rounding.
- R5: Rounding adds double fraction bit 11 to the kept 40 bits. A dropped field of 0x800 or more rounds up, and 0x7FF or less truncates.
- R6: When rounding carries out of the 40-bit fraction, the carry is discarded. The fraction becomes zero and the exponent field does not change.
- R7: A rebased exponent above 127 saturates to 127, and one below 0 saturates to 0. The sign and the rounded fraction are kept in both cases.
- R8: A double whose 11-bit exponent is zero narrows to all zeros. This covers +0.0, -0.0 and denormals of either sign.
- R9: Each accepted byte (`byteValid` high) fills the next byte lane. Lane k occupies `asmWord` bits 8k+7..8k, and lane 0 comes first after reset or after a completed word. In the cycle after the sixth byte is accepted, `asmDone` is high for exactly one cycle and `asmWord` holds all six bytes.
- R10: A byte accepted with `byteFirst` high goes to lane 0 whatever the current position, which abandons any partial word.
- R11: Cycles with `byteValid` low do not advance the lane position and do not raise `asmDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| unpackReq | input | 1 | Widen request for `rawIn` |
| rawIn | input | 48 | 48-bit word to widen |
| unpackDone | output | 1 | `dblOut` updated this cycle |
| dblOut | output | 64 | Widened binary64 result |
| packReq | input | 1 | Narrow request for `dblIn` |
| dblIn | input | 64 | binary64 value to narrow |
| packDone | output | 1 | `packOut` updated this cycle |
| packOut | output | 48 | Narrowed 48-bit result |
| byteValid | input | 1 | `byteData` is presented this cycle |
| byteFirst | input | 1 | Current byte is the lowest address of a word |
| byteData | input | 8 | Byte read from memory |
| asmDone | output | 1 | `asmWord` completed this cycle |
| asmWord | output | 48 | Gathered 48-bit word |

## Verification
The only internal state is the lane position of the byte gatherer and the output registers. A wrong lane position shows up as bytes swapped or shifted inside `asmWord`, or as `asmDone` arriving early or late. This is visible as soon as the next word completes, at most six accepted bytes later. The conversion paths have no memory beyond one register, so a fault in rebiasing, rounding, clamping or the zero test appears at `dblOut` or `packOut` in the cycle right after the request. The directed values therefore sit on the rounding tie, the carry wrap, both clamp limits and the exponent-zero boundary.

// File: rtl/fmt48_pkg.sv
package fmt48_pkg;
  // compact 48-bit word layout
  localparam int CW_W      = 48;
  localparam int CW_EXP_W  = 7;
  localparam int CW_FRAC_W = 40;
  localparam int CW_BIAS   = 64;
  // binary64 layout
  localparam int DW_W      = 64;
  localparam int DW_EXP_W  = 11;
  localparam int DW_FRAC_W = 52;
  localparam int DW_BIAS   = 1023;
  // derived
  localparam int DROP_W    = DW_FRAC_W - CW_FRAC_W;
  localparam int REBIAS    = DW_BIAS - CW_BIAS;
  localparam int EXP_MAX   = (1 << CW_EXP_W) - 1;
  localparam int BYTE_W    = 8;
  localparam int ASM_BYTES = CW_W / BYTE_W;
  localparam int LANE_W    = (ASM_BYTES > 1) ? $clog2(ASM_BYTES) : 1;

  typedef struct packed {
    logic [ASM_BYTES-1:0] laneWe;
    logic                 asmFire;
    logic                 unpackLoad;
    logic                 packLoad;
  } ctlStrobe_t;
endpackage

// File: rtl/fmt48_ctl.sv
module fmt48_ctl
  import fmt48_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       unpackReq,
  input  logic       packReq,
  input  logic       byteValid,
  input  logic       byteFirst,
  output ctlStrobe_t strobe
);
  logic [LANE_W-1:0] laneCnt;
  logic [LANE_W-1:0] laneIdx;
  logic              lastLane;

  assign laneIdx  = byteFirst ? '0 : laneCnt;
  assign lastLane = (laneIdx == LANE_W'(ASM_BYTES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      laneCnt <= '0;
    end else if (byteValid) begin
      laneCnt <= lastLane ? '0 : laneIdx + LANE_W'(1);
    end
  end

  always_comb begin
    strobe            = '0;
    strobe.laneWe     = byteValid ? (ASM_BYTES'(1) << laneIdx) : '0;
    strobe.asmFire    = byteValid && lastLane;
    strobe.unpackLoad = unpackReq;
    strobe.packLoad   = packReq;
  end

  // R9
  lane_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.laneWe));

  // R11
  idle_no_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    !byteValid |-> !strobe.asmFire && (strobe.laneWe == '0));
endmodule

// File: rtl/fmt48_dp.sv
module fmt48_dp
  import fmt48_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strobe,
  input  logic [CW_W-1:0]     rawIn,
  input  logic [DW_W-1:0]     dblIn,
  input  logic [BYTE_W-1:0]   byteData,
  output logic                unpackDone,
  output logic [DW_W-1:0]     dblOut,
  output logic                packDone,
  output logic [CW_W-1:0]     packOut,
  output logic                asmDone,
  output logic [CW_W-1:0]     asmWord
);
  localparam int RB_W = DW_EXP_W + 2;

  // ---------------- widen path ----------------
  logic                 rawSign;
  logic [CW_EXP_W-1:0]  rawExp;
  logic [CW_FRAC_W-1:0] rawFrac;
  logic [DW_EXP_W-1:0]  wideExp;
  logic [DW_W-1:0]      wideVal;

  assign rawSign = rawIn[CW_W-1];
  assign rawExp  = rawIn[CW_W-2 -: CW_EXP_W];
  assign rawFrac = rawIn[CW_FRAC_W-1:0];
  assign wideExp = DW_EXP_W'(rawExp) + DW_EXP_W'(REBIAS);

  always_comb begin
    if (rawIn == '0) wideVal = '0;
    else             wideVal = {rawSign, wideExp, rawFrac, {DROP_W{1'b0}}};
  end

  // ---------------- narrow path ----------------
  logic                   dSign;
  logic [DW_EXP_W-1:0]    dExp;
  logic [DW_FRAC_W-1:0]   dFrac;
  logic signed [RB_W-1:0] rebased;
  logic [CW_EXP_W-1:0]    expField;
  logic [CW_FRAC_W-1:0]   roundFrac;
  logic [CW_W-1:0]        narrowVal;

  assign dSign   = dblIn[DW_W-1];
  assign dExp    = dblIn[DW_W-2 -: DW_EXP_W];
  assign dFrac   = dblIn[DW_FRAC_W-1:0];
  assign rebased = $signed({2'b00, dExp}) - $signed(RB_W'(REBIAS));

  always_comb begin
    if (rebased < $signed(RB_W'(0)))             expField = '0;
    else if (rebased > $signed(RB_W'(EXP_MAX)))  expField = CW_EXP_W'(EXP_MAX);
    else                                         expField = rebased[CW_EXP_W-1:0];
  end

  // carry out of the fraction falls off the top
  assign roundFrac = dFrac[DW_FRAC_W-1:DROP_W] + CW_FRAC_W'(dFrac[DROP_W-1]);

  always_comb begin
    if (dExp == '0) narrowVal = '0;
    else            narrowVal = {dSign, expField, roundFrac};
  end

  // ---------------- byte gatherer ----------------
  logic [BYTE_W-1:0] laneReg [ASM_BYTES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < ASM_BYTES; k++) laneReg[k] <= '0;
    end else begin
      for (int k = 0; k < ASM_BYTES; k++)
        if (strobe.laneWe[k]) laneReg[k] <= byteData;
    end
  end

  for (genvar g = 0; g < ASM_BYTES; g++) begin : g_lane
    assign asmWord[g*BYTE_W +: BYTE_W] = laneReg[g];
  end

  // ---------------- output registers ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unpackDone <= 1'b0;
      packDone   <= 1'b0;
      asmDone    <= 1'b0;
      dblOut     <= '0;
      packOut    <= '0;
    end else begin
      unpackDone <= strobe.unpackLoad;
      packDone   <= strobe.packLoad;
      asmDone    <= strobe.asmFire;
      if (strobe.unpackLoad) dblOut  <= wideVal;
      if (strobe.packLoad)   packOut <= narrowVal;
    end
  end

  // R2
  unpack_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.unpackLoad |=> unpackDone && (dblOut[DW_W-1] == $past(rawIn[CW_W-1])));

  // R3
  unpack_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.unpackLoad && (rawIn == '0) |=> (dblOut == '0));

  // R4
  pack_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.packLoad && (dExp != '0) |=> packDone && (packOut[CW_W-1] == $past(dblIn[DW_W-1])));

  // R8
  pack_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.packLoad && (dExp == '0) |=> (packOut == '0));

  // R9
  asm_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    asmDone |=> !asmDone);
endmodule

// File: rtl/fmt48_bridge.sv
module fmt48_bridge
  import fmt48_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              unpackReq,
  input  logic [CW_W-1:0]   rawIn,
  output logic              unpackDone,
  output logic [DW_W-1:0]   dblOut,
  input  logic              packReq,
  input  logic [DW_W-1:0]   dblIn,
  output logic              packDone,
  output logic [CW_W-1:0]   packOut,
  input  logic              byteValid,
  input  logic              byteFirst,
  input  logic [BYTE_W-1:0] byteData,
  output logic              asmDone,
  output logic [CW_W-1:0]   asmWord
);
  ctlStrobe_t strobe;

  fmt48_ctl i_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .unpackReq (unpackReq),
    .packReq   (packReq),
    .byteValid (byteValid),
    .byteFirst (byteFirst),
    .strobe    (strobe)
  );

  fmt48_dp i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .rawIn      (rawIn),
    .dblIn      (dblIn),
    .byteData   (byteData),
    .unpackDone (unpackDone),
    .dblOut     (dblOut),
    .packDone   (packDone),
    .packOut    (packOut),
    .asmDone    (asmDone),
    .asmWord    (asmWord)
  );
endmodule

// File: tb/test_fmt48_bridge.sv
module test_fmt48_bridge;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        unpackReq = 1'b0;
  logic [47:0] rawIn = '0;
  logic        unpackDone;
  logic [63:0] dblOut;
  logic        packReq = 1'b0;
  logic [63:0] dblIn = '0;
  logic        packDone;
  logic [47:0] packOut;
  logic        byteValid = 1'b0;
  logic        byteFirst = 1'b0;
  logic [7:0]  byteData = '0;
  logic        asmDone;
  logic [47:0] asmWord;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  fmt48_bridge i_fmt48_bridge (
    .clk(clk), .rstN(rstN),
    .unpackReq(unpackReq), .rawIn(rawIn), .unpackDone(unpackDone), .dblOut(dblOut),
    .packReq(packReq), .dblIn(dblIn), .packDone(packDone), .packOut(packOut),
    .byteValid(byteValid), .byteFirst(byteFirst), .byteData(byteData),
    .asmDone(asmDone), .asmWord(asmWord)
  );

  task automatic checkVal(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doUnpack(input string tag, input logic [47:0] raw, input logic [63:0] exp);
    @(negedge clk);
    unpackReq = 1'b1; rawIn = raw;
    @(negedge clk);
    unpackReq = 1'b0;
    checkVal({tag, " done"}, 64'(unpackDone), 64'd1);
    checkVal(tag, dblOut, exp);
  endtask

  task automatic doPack(input string tag, input logic [63:0] dbl, input logic [47:0] exp);
    @(negedge clk);
    packReq = 1'b1; dblIn = dbl;
    @(negedge clk);
    packReq = 1'b0;
    checkVal({tag, " done"}, 64'(packDone), 64'd1);
    checkVal(tag, 64'(packOut), 64'(exp));
  endtask

  task automatic sendByte(input logic [7:0] b, input logic first);
    @(negedge clk);
    byteValid = 1'b1; byteFirst = first; byteData = b;
  endtask

  task automatic endBytes(input string tag, input logic [47:0] exp);
    @(negedge clk);
    byteValid = 1'b0; byteFirst = 1'b0;
    checkVal({tag, " done"}, 64'(asmDone), 64'd1);
    checkVal(tag, 64'(asmWord), 64'(exp));
    @(negedge clk);
    checkVal({tag, " pulse"}, 64'(asmDone), 64'd0);
  endtask

  // R1
  task automatic testReset();
    checkVal("R1 unpackDone", 64'(unpackDone), 64'd0);
    checkVal("R1 packDone", 64'(packDone), 64'd0);
    checkVal("R1 asmDone", 64'(asmDone), 64'd0);
    checkVal("R1 dblOut", dblOut, 64'd0);
    checkVal("R1 packOut", 64'(packOut), 64'd0);
    checkVal("R1 asmWord", 64'(asmWord), 64'd0);
  endtask

  task automatic testWiden();
    doUnpack("R2 one", 48'h400000000000, 64'h3FF0000000000000);
    doUnpack("R2 pos", 48'h412345678ABC, 64'h4002345678ABC000);
    doUnpack("R2 neg", 48'hC12345678ABC, 64'hC002345678ABC000);
    doUnpack("R2 maxexp", 48'h7FFFFFFFFFFF, 64'h43EFFFFFFFFFF000);
    doUnpack("R3 zero", 48'h000000000000, 64'h0);
    doUnpack("R3 signonly", 48'h800000000000, 64'hBBF0000000000000);
  endtask

  task automatic testNarrow();
    doPack("R4 one", 64'h3FF0000000000000, 48'h400000000000);
    doPack("R4 neg two", 64'hC000000000000000, 48'hC10000000000);
    doPack("R4 frac", 64'h4002345678ABC000, 48'h412345678ABC);
    doPack("R5 tie up", 64'h3FF0000000000800, 48'h400000000001);
    doPack("R5 below", 64'h3FF00000000007FF, 48'h400000000000);
    doPack("R5 above", 64'h3FF0000000000FFF, 48'h400000000001);
    doPack("R6 carry", 64'h3FFFFFFFFFFFF800, 48'h400000000000);
    doPack("R7 top edge", 64'h43E0000000000000, 48'h7F0000000000);
    doPack("R7 high", 64'h7FE0000000000000, 48'h7F0000000000);
    doPack("R7 high neg", 64'hC3F0000000000000, 48'hFF0000000000);
    doPack("R7 low edge", 64'h3C00000000000000, 48'h010000000000);
    doPack("R7 exp959", 64'h3BF0000000000000, 48'h000000000000);
    doPack("R7 low frac", 64'h001123456789A000, 48'h00123456789A);
    doPack("R8 pos zero", 64'h0000000000000000, 48'h0);
    doPack("R8 neg zero", 64'h8000000000000000, 48'h0);
    doPack("R8 denorm", 64'h000FFFFFFFFFFFFF, 48'h0);
    doPack("R8 neg denorm", 64'h8000000000000001, 48'h0);
  endtask

  task automatic testGather();
    logic [7:0] seqA [6] = '{8'hBC, 8'h8A, 8'h78, 8'h56, 8'h34, 8'h12};
    // R9: first word after reset, byteFirst left low
    for (int i = 0; i < 6; i++) begin
      sendByte(seqA[i], 1'b0);
      if (i == 5) checkVal("R9 not early", 64'(asmDone), 64'd0);
    end
    endBytes("R9 word", 48'h123456788ABC);
    // R9: next word continues from lane 0 without byteFirst
    for (int i = 0; i < 6; i++) sendByte(8'(8'h10 + i), 1'b0);
    endBytes("R9 wrap", 48'h151413121110);
    // R11: idle gaps between bytes
    for (int i = 0; i < 6; i++) begin
      sendByte(8'(8'hA0 + i), 1'b0);
      @(negedge clk); byteValid = 1'b0;
      @(negedge clk);
      checkVal("R11 idle", 64'(asmDone), 64'd0);
    end
    @(negedge clk);
    checkVal("R11 gap word", 64'(asmWord), 64'hA5A4A3A2A1A0);
    // R10: partial word abandoned by byteFirst
    for (int i = 0; i < 3; i++) sendByte(8'hEE, 1'b0);
    for (int i = 0; i < 6; i++) sendByte(8'(8'h61 + i), (i == 0));
    endBytes("R10 restart", 48'h666564636261);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWiden();
    testNarrow();
    testGather();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule